// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits between a simple request port and a 16-bit asynchronous EDO DRAM. Each request carries a 20-bit word address, a write flag, two byte-enable bits and write data. The sequencer drives the strobe and multiplexed-address pins so that each request becomes a complete memory access. The upper ten address bits go out as the row, strobed by the falling row strobe. The lower ten bits follow as the column, strobed by the falling column strobe. Each of the two column strobes covers one byte lane.

After an access the row stays open. A later request that hits the same row is served as a page cycle: only the column strobe toggles again. A request to a different row first raises the row strobe for a programmable precharge time. The time the row strobe stays low is counted. When too little budget remains for one more page cycle, the row is closed even if no request is waiting. All delays are clock-cycle counts set by parameters.

Writes are early writes. Write enable and the data are set up one cycle before the column strobe falls, and the output enable stays high. Reads hold output enable low and write enable high. The returned word is sampled at the end of the column precharge, which relies on the extended-data-out hold. It comes back with a one-cycle valid pulse.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and straight after it, the row strobe, both column strobes, write enable and output enable are high, data drive and read valid are low, and req_ready is high.
- R2: The row strobe falls with req_addr[19:10] on mem_addr. The column strobe falls with req_addr[9:0] on mem_addr.
- R3: mem_lcas_n (data bits 7..0) goes low only if req_be[0] is set, and mem_ucas_n (bits 15..8) only if req_be[1] is set. A write changes only the enabled bytes. A column strobe is never low while the row strobe is high.
- R4: A column strobe falls no earlier than T_RCD+1 cycles after the row strobe falls. It stays low exactly T_CAS cycles. The row strobe stays high at least T_RP cycles between rows.
- R5: For a write, mem_we_n is low and data is driven at least one cycle before the column strobe falls, while mem_oe_n stays high. mem_dq_oe is only ever high while mem_we_n is low.
- R6: A read holds mem_oe_n low with mem_we_n high. The word on mem_dq_in is sampled when CAS precharge ends and returned on rd_data with a one-cycle rd_valid pulse. From a closed row, the pulse comes T_RCD+T_CAS+T_CP+2 cycles after acceptance.
- R7: A request to the open row, accepted while the budget allows, is served without the row strobe rising. Its read pulse comes T_CAS+T_CP+2 cycles after acceptance.
- R8: A request to another row raises the row strobe for T_RP cycles and then opens the new row. Its read pulse comes T_RP+T_RCD+T_CAS+T_CP+2 cycles after acceptance.
- R9: The row strobe is never low for more than T_RASP consecutive cycles. An idle open row is closed on its own once the remaining budget cannot fit another page cycle.
- R10: req_ready is high only when the sequencer is idle with no row open, or idle with a row open and budget left. It is low in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 20 | Word address, row in upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | 16 | Returned read word |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_ucas_n | output | 1 | Upper-byte column strobe, active low |
| mem_lcas_n | output | 1 | Lower-byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bound checker watches the pin-level rules on every cycle. It checks that a column strobe is low only inside a row, the minimum row-to-column delay, the exact column pulse width, and the minimum precharge. It also checks the maximum row-low time, the pairing of write enable with data drive and output enable, the early setup of write enable, and the single-cycle read pulse. Only the bench scenarios can show that the right row and column reach the pins, and that enabled bytes and no others are written. They also show that a read returns the stored word at the stated latency, that hits keep the row open while misses reopen it, and that an idle row is closed by the budget.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, waiting
        ST_RCD,    // row strobe low, waiting out row-to-column delay
        ST_COL,    // column address and command set up
        ST_CAS,    // column strobe low
        ST_CP,     // column precharge, read data sampled at its end
        ST_OPEN,   // row open, waiting
        ST_PRE     // row precharge
    } edo_state_e;
endpackage

// File: rtl/edo_wait_timer.sv
module edo_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = value_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
    parameter int ROW_W  = 10,
    parameter int CNT_W  = 15,
    parameter int LIMIT  = 10000,
    parameter int MARGIN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_low_i,
    input  logic             load_i,
    input  logic [ROW_W-1:0] load_row_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             hit_o,
    output logic             budget_ok_o
);
    localparam logic [CNT_W-1:0] THRESH  = CNT_W'(LIMIT - MARGIN);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        if (!ras_low_i)
            cnt_d = '0;
        else if (cnt_q == CNT_TOP)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        row_d = load_i ? load_row_i : row_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            row_q <= row_d;
        end
    end

    assign hit_o       = ras_low_i && (row_q == cmp_row_i);
    assign budget_ok_o = (cnt_q < THRESH);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_CP   = 1,
    parameter int T_RP   = 2,
    parameter int T_RASP = 10000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ROW_W+COL_W-1:0]       req_addr,
    input  logic                         req_write,
    input  logic [1:0]                   req_be,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         mem_ras_n,
    output logic                         mem_ucas_n,
    output logic                         mem_lcas_n,
    output logic                         mem_we_n,
    output logic                         mem_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_dq_out,
    output logic                         mem_dq_oe,
    input  logic [DATA_W-1:0]            mem_dq_in
);
    localparam int ADDR_W      = ROW_W + COL_W;
    localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TMAX_A      = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TMAX_B      = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMR_MAX     = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);
    localparam int RASP_W      = $clog2(T_RASP + 1) + 1;
    localparam int PAGE_MARGIN = T_CAS + T_CP + 3;

    typedef struct packed {
        edo_state_e        state;
        logic              ras_n;
        logic              ucas_n;
        logic              lcas_n;
        logic              we_n;
        logic              oe_n;
        logic [MUX_W-1:0]  addr;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              pending;
        logic [ADDR_W-1:0] r_addr;
        logic              r_write;
        logic [1:0]        r_be;
        logic [DATA_W-1:0] r_wdata;
    } ctl_t;

    ctl_t q, d;

    logic              t_load, t_done;
    logic [TMR_W-1:0]  t_val;
    logic              row_load, row_hit, budget_ok;
    logic [ROW_W-1:0]  row_val;

    // Capture an incoming request into the held copy.
    function automatic ctl_t take_req(input ctl_t s, input logic [ADDR_W-1:0] a,
                                      input logic w, input logic [1:0] b,
                                      input logic [DATA_W-1:0] wd);
        ctl_t r = s;
        r.r_addr  = a;
        r.r_write = w;
        r.r_be    = b;
        r.r_wdata = wd;
        return r;
    endfunction

    // Column setup cycle: column on the bus, command pins one cycle ahead of the strobe.
    function automatic ctl_t col_setup(input ctl_t s);
        ctl_t r = s;
        r.state = ST_COL;
        r.addr  = MUX_W'(s.r_addr[COL_W-1:0]);
        if (s.r_write) begin
            r.we_n   = 1'b0;
            r.oe_n   = 1'b1;
            r.dq_oe  = 1'b1;
            r.dq_out = s.r_wdata;
        end else begin
            r.we_n  = 1'b1;
            r.oe_n  = 1'b0;
            r.dq_oe = 1'b0;
        end
        return r;
    endfunction

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        row_load   = 1'b0;
        row_val    = q.r_addr[ADDR_W-1:COL_W];
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d        = take_req(d, req_addr, req_write, req_be, req_wdata);
                    d.state  = ST_RCD;
                    d.ras_n  = 1'b0;
                    d.addr   = MUX_W'(req_addr[ADDR_W-1:COL_W]);
                    t_load   = 1'b1;
                    t_val    = TMR_W'(T_RCD - 1);
                    row_load = 1'b1;
                    row_val  = req_addr[ADDR_W-1:COL_W];
                end
            end
            ST_RCD: begin
                if (t_done) d = col_setup(q);
            end
            ST_COL: begin
                d.state  = ST_CAS;
                d.ucas_n = !q.r_be[1];
                d.lcas_n = !q.r_be[0];
                t_load   = 1'b1;
                t_val    = TMR_W'(T_CAS - 1);
            end
            ST_CAS: begin
                if (t_done) begin
                    d.state  = ST_CP;
                    d.ucas_n = 1'b1;
                    d.lcas_n = 1'b1;
                    d.we_n   = 1'b1;
                    d.dq_oe  = 1'b0;
                    t_load   = 1'b1;
                    t_val    = TMR_W'(T_CP - 1);
                end
            end
            ST_CP: begin
                if (t_done) begin
                    d.state = ST_OPEN;
                    d.oe_n  = 1'b1;
                    if (!q.r_write) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = mem_dq_in;
                    end
                end
            end
            ST_OPEN: begin
                if (!budget_ok) begin
                    d.state   = ST_PRE;
                    d.ras_n   = 1'b1;
                    d.pending = 1'b0;
                    t_load    = 1'b1;
                    t_val     = TMR_W'(T_RP - 1);
                end else if (req_valid) begin
                    d = take_req(d, req_addr, req_write, req_be, req_wdata);
                    if (row_hit) begin
                        d = col_setup(d);
                    end else begin
                        d.state   = ST_PRE;
                        d.ras_n   = 1'b1;
                        d.pending = 1'b1;
                        t_load    = 1'b1;
                        t_val     = TMR_W'(T_RP - 1);
                    end
                end
            end
            ST_PRE: begin
                if (t_done) begin
                    if (q.pending) begin
                        d.state   = ST_RCD;
                        d.ras_n   = 1'b0;
                        d.pending = 1'b0;
                        d.addr    = MUX_W'(q.r_addr[ADDR_W-1:COL_W]);
                        t_load    = 1'b1;
                        t_val     = TMR_W'(T_RCD - 1);
                        row_load  = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.ras_n  <= 1'b1;
            q.ucas_n <= 1'b1;
            q.lcas_n <= 1'b1;
            q.we_n   <= 1'b1;
            q.oe_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    edo_wait_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (t_load),
        .value_i (t_val),
        .done_o  (t_done)
    );

    edo_row_tracker #(
        .ROW_W  (ROW_W),
        .CNT_W  (RASP_W),
        .LIMIT  (T_RASP),
        .MARGIN (PAGE_MARGIN)
    ) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_low_i   (!q.ras_n),
        .load_i      (row_load),
        .load_row_i  (row_val),
        .cmp_row_i   (req_addr[ADDR_W-1:COL_W]),
        .hit_o       (row_hit),
        .budget_ok_o (budget_ok)
    );

    assign req_ready  = (q.state == ST_IDLE) || ((q.state == ST_OPEN) && budget_ok);
    assign rd_valid   = q.rd_valid;
    assign rd_data    = q.rd_data;
    assign mem_ras_n  = q.ras_n;
    assign mem_ucas_n = q.ucas_n;
    assign mem_lcas_n = q.lcas_n;
    assign mem_we_n   = q.we_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_addr   = q.addr;
    assign mem_dq_out = q.dq_out;
    assign mem_dq_oe  = q.dq_oe;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2,
    parameter int T_RASP = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic ucas_n,
    input logic lcas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rd_valid
);
    localparam int CW = $clog2(T_RASP + T_RP + 8) + 1;
    localparam logic [CW-1:0] TOP = '1;

    logic          cas_hi;
    logic [CW-1:0] lo_cnt, hi_cnt, cas_cnt;

    assign cas_hi = ucas_n & lcas_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            hi_cnt  <= CW'(T_RP);
            cas_cnt <= '0;
        end else begin
            lo_cnt  <= ras_n  ? '0 : ((lo_cnt == TOP) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt  <= !ras_n ? '0 : ((hi_cnt == TOP) ? hi_cnt : hi_cnt + 1'b1);
            cas_cnt <= cas_hi ? '0 : ((cas_cnt == TOP) ? cas_cnt : cas_cnt + 1'b1);
        end
    end

    assert_cas_inside_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_hi |-> !ras_n);

    assert_row_to_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_hi) |-> (lo_cnt >= CW'(T_RCD + 1)));

    assert_cas_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_hi) |-> (cas_cnt == CW'(T_CAS)));

    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= CW'(T_RP)));

    assert_row_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= CW'(T_RASP));

    assert_drive_only_writing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n);

    assert_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_hi) && !we_n) |-> $past(!we_n));

    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n);

    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP),
    .T_RASP (T_RASP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (mem_ras_n),
    .ucas_n   (mem_ucas_n),
    .lcas_n   (mem_lcas_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe),
    .rd_valid (rd_valid)
);

// File: tb/test_edo_page_ctrl.sv
module test_edo_page_ctrl;
    localparam int T_RCD  = 2;
    localparam int T_CAS  = 2;
    localparam int T_CP   = 2;
    localparam int T_RP   = 3;
    localparam int T_RASP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [9:0]  mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    always #10 clk = ~clk;

    edo_page_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASP(T_RASP)
    ) i_edo_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ras_n(mem_ras_n),
        .mem_ucas_n(mem_ucas_n), .mem_lcas_n(mem_lcas_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- bench counters ----------------
    int n_cmp = 0, n_bad = 0;   // main sequence
    int m_cmp = 0, m_bad = 0;   // memory model
    bit done_flag = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        m_cmp++;
        if (act !== exp) begin
            m_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [bit [19:0]];
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = '0;
    logic [9:0]  m_row = '0;
    logic [15:0] dq_in_m = 16'hDEAD;
    logic        prev_ras = 1'b1, prev_cashi = 1'b1, prev_we = 1'b1;
    int          ras_falls = 0, lo_run = 0, hi_run = 1000, cas_run = 0;
    int          max_lo = 0, min_hi = 1000;

    assign mem_dq_in = dq_in_m;

    function automatic logic [15:0] peek(input logic [19:0] a);
        if (mem.exists(a)) return mem[a];
        return 16'h0000;
    endfunction

    always @(negedge clk) begin
        logic        cashi;
        logic [19:0] k;
        logic [15:0] w;
        if (rst_n) begin
            cashi = mem_ucas_n & mem_lcas_n;
            if (prev_ras && !mem_ras_n) begin
                ras_falls++;
                m_row = mem_addr;
                mchk("R2 row address at row strobe", {22'd0, mem_addr}, {22'd0, cur_addr[19:10]});
                if (hi_run < min_hi) min_hi = hi_run;
            end
            if (prev_cashi && !cashi) begin
                k = {m_row, mem_addr};
                mchk("R2 column address at column strobe", {22'd0, mem_addr}, {22'd0, cur_addr[9:0]});
                mchk("R3 column strobe lanes", {30'd0, !mem_ucas_n, !mem_lcas_n}, {30'd0, cur_be});
                if (!mem_we_n) begin
                    mchk("R5 write enable set before strobe", {31'd0, prev_we}, 32'd0);
                    mchk("R5 data driven and oe high", {30'd0, mem_dq_oe, mem_oe_n}, 32'd3);
                    w = peek(k);
                    if (!mem_lcas_n) w[7:0]  = mem_dq_out[7:0];
                    if (!mem_ucas_n) w[15:8] = mem_dq_out[15:8];
                    mem[k] = w;
                end else begin
                    mchk("R6 read pins oe low no drive", {30'd0, mem_oe_n, mem_dq_oe}, 32'd0);
                    dq_in_m = peek(k);
                end
            end
            if (!prev_cashi && cashi)
                mchk("R4 column strobe width", cas_run, T_CAS);
            if (!prev_ras && mem_ras_n) dq_in_m = 16'hDEAD;
            if (!mem_ras_n) begin
                lo_run++;
                hi_run = 0;
                if (lo_run > max_lo) max_lo = lo_run;
            end else begin
                lo_run = 0;
                hi_run++;
            end
            cas_run    = cashi ? 0 : cas_run + 1;
            prev_ras   = mem_ras_n;
            prev_cashi = cashi;
            prev_we    = mem_we_n;
        end
    end

    // ---------------- request driver ----------------
    int          last_lat = 0;
    logic [15:0] last_rd = '0;
    logic        ready_after = 1'b0;

    task automatic do_req(input logic wr, input logic [1:0] be,
                          input logic [19:0] a, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_be    = be;
        req_addr  = a;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        cur_addr = a;
        cur_be   = be;
        @(negedge clk);
        req_valid   = 1'b0;
        ready_after = req_ready;
        last_lat    = 1;
        if (!wr) begin
            while (!rd_valid && last_lat < 300) begin
                @(negedge clk);
                last_lat++;
            end
            last_rd = rd_data;
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_bad + m_bad);
    endtask

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic        wr;
        logic [1:0]  be;
        logic [19:0] addr;
        logic [15:0] data;   // write data, or expected read word
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b11, 20'h12345, 16'hA5C3},
        '{1'b0, 2'b11, 20'h12345, 16'hA5C3},  // page hit read back
        '{1'b1, 2'b01, 20'h12346, 16'h1122},  // lower byte only
        '{1'b1, 2'b10, 20'h12346, 16'h7788},  // upper byte only
        '{1'b0, 2'b11, 20'h12346, 16'h7722},
        '{1'b1, 2'b11, 20'h40000, 16'hBEEF},  // new row
        '{1'b0, 2'b11, 20'h12345, 16'hA5C3},  // back to old row
        '{1'b0, 2'b11, 20'h40000, 16'hBEEF},
        '{1'b0, 2'b01, 20'h12346, 16'h7722}   // lower byte read
    };

    initial begin
        int falls0;
        logic [15:0] mask;
        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1 strobes high in reset", {27'd0, mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n}, 32'h1F);
        chk("R1 no drive no read pulse", {30'd0, mem_dq_oe, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 row closed after reset", {31'd0, mem_ras_n}, 32'd1);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].wr, VECS[i].be, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) begin
                mask = {{8{VECS[i].be[1]}}, {8{VECS[i].be[0]}}};
                chk("R3 R6 read word", {16'd0, last_rd & mask}, {16'd0, VECS[i].data & mask});
            end
        end

        // R9 idle open row closes by itself
        repeat (T_RASP + 20) @(negedge clk);
        chk("R9 idle row closed", {31'd0, mem_ras_n}, 32'd1);
        chk("R10 ready when closed", {31'd0, req_ready}, 32'd1);

        // R6 closed-row read latency, R10 ready drops
        falls0 = ras_falls;
        do_req(1'b0, 2'b11, 20'h40000, 16'h0);
        chk("R10 ready low after accept", {31'd0, ready_after}, 32'd0);
        chk("R6 closed read latency", last_lat, T_RCD + T_CAS + T_CP + 2);
        chk("R6 closed read data", {16'd0, last_rd}, 32'hBEEF);

        // R7 page hit
        do_req(1'b0, 2'b11, 20'h40000, 16'h0);
        chk("R7 hit latency", last_lat, T_CAS + T_CP + 2);
        chk("R7 no new row strobe", ras_falls - falls0, 1);

        // R8 miss
        do_req(1'b0, 2'b11, 20'h12345, 16'h0);
        chk("R8 miss latency", last_lat, T_RP + T_RCD + T_CAS + T_CP + 2);
        chk("R8 reopened row", ras_falls - falls0, 2);
        chk("R8 read after miss", {16'd0, last_rd}, 32'hA5C3);

        // R9 stream of hits forces budget closures
        falls0 = ras_falls;
        for (int j = 0; j < 30; j++) begin
            do_req(1'b0, 2'b11, 20'h12345, 16'h0);
            chk("R9 stream read data", {16'd0, last_rd}, 32'hA5C3);
        end
        chk("R9 row reopened during stream", {31'd0, (ras_falls - falls0) >= 1}, 32'd1);
        chk("R9 longest row-low run", {31'd0, max_lo <= T_RASP}, 32'd1);
        chk("R4 shortest precharge", {31'd0, min_hi >= T_RP}, 32'd1);

        repeat (5) @(negedge clk);
        done_flag = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule